// File: doc/BRIEF.md
# Slow-Clock System Timer

This peripheral keeps time from a 32768 Hz slow-clock enable that arrives as a one-cycle pulse (`tick_en`) in the bus clock domain. A 20-bit free-running count advances once per prescale interval and wraps modulo 2^20. A reload prescaler sets that interval in slow ticks. After reset it is 32768 ticks, one second. Programmed to 1, the count advances on every slow tick and a full wrap takes 32 seconds.

Two event sources watch the time base. An absolute alarm fires when the count steps into a programmed value. A periodic interval timer fires once every programmed number of slow ticks and reloads without drift. Each event source sets a sticky status bit, as do every count increment and an external watchdog-overflow input. A single read of the status register returns the bits and clears them. The interrupt line is raised by any status bit that is enabled in the mask. The mask is changed only through separate set-bits and clear-bits registers.

Software drives the timer through a synchronous register port with separate read and write strobes. Read data is registered one clock after the read strobe.

Top module: `slowtick_timer`

Register addresses (`addr`):

| addr | Register | Access |
|------|----------|--------|
| 0 | count | read only |
| 1 | prescale | read/write |
| 2 | alarm | read/write |
| 3 | period | read/write |
| 4 | status | read clears |
| 5 | mask set | write only |
| 6 | mask clear | write only |
| 7 | mask | read only |

Status and mask bit positions: bit 0 periodic, bit 1 watchdog, bit 2 increment, bit 3 alarm.

## Requirements
- R1: After reset the count is 0, prescale is 32768, alarm is 0, period is 65535, and status, mask and `irq` are all 0.
- R2: The count advances once every N slow ticks, where N is the prescale register at addr 1 (a value of 0 behaves as 1). Writing the prescale register restarts the tick phase from zero.
- R3: A read of addr 0 returns the 20-bit count in bits 19:0, zero-extended, as registered at the read edge (the value before any increment at that same edge). The count wraps from 2^20-1 to 0, and writes to addr 0 are ignored.
- R4: Status bit 3 (alarm) sets when the count advances into a value equal to the alarm register at addr 2.
- R5: Writing the alarm register with the value the count currently holds produces no alarm until the count wraps around to that value.
- R6: Status bit 0 (periodic) sets on every P-th slow tick, where P is the period register at addr 3 (0 behaves as 1). Writing the period restarts the interval, and the period repeats without drift.
- R7: A read of the status register at addr 4 returns the four status bits and clears all of them.
- R8: A status event in the same cycle as a status read wins: its bit is set after the read.
- R9: While `wd_ovf_in` is high, status bit 1 (watchdog) is set.
- R10: Writing 1s to addr 5 sets mask bits and writing 1s to addr 6 clears them. Zero bits in either write have no effect, and the mask reads back at addr 7.
- R11: `irq` is high exactly when some status bit is set whose mask bit is also set.
- R12: Status bit 2 (increment) sets on every count increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle slow-clock tick enable |
| wd_ovf_in | input | 1 | Watchdog overflow indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, OR of the masked status bits |

## Verification
A wrong prescale phase or a wrong period phase appears at the ports as an interrupt or a count that is one slow tick early or late. The bench therefore checks `irq` after every single tick across several periods, and reads the count against a model after each burst of ticks. A status register that fails to clear, or that loses an event during a read, shows up on the very next status read. A bad alarm compare shows as `irq` rising on the wrong tick, or rising after the alarm has been cancelled by writing the current count.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int unsigned ST_PIT = 0;
  localparam int unsigned ST_WDG = 1;
  localparam int unsigned ST_INC = 2;
  localparam int unsigned ST_ALM = 3;
  localparam int unsigned ST_W   = 4;

  typedef enum logic [2:0] {
    A_CNT    = 3'd0,
    A_PRESC  = 3'd1,
    A_ALARM  = 3'd2,
    A_PERIOD = 3'd3,
    A_STATUS = 3'd4,
    A_MSET   = 3'd5,
    A_MCLR   = 3'd6,
    A_MASK   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/stt_rtc.sv
module stt_rtc #(
  parameter int CNT_W = 20,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             presc_load,
  input  logic [PRE_W-1:0] presc,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             inc_ev
);
  // last phase index of a prescale interval; 0 acts as 1
  function automatic logic [PRE_W-1:0] final_phase(input logic [PRE_W-1:0] p);
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  logic [PRE_W-1:0] phase_q;

  assign inc_ev   = tick_en && !presc_load && (phase_q >= final_phase(presc));
  assign cnt_next = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cnt     <= '0;
    end else begin
      if (presc_load)   phase_q <= '0;
      else if (inc_ev)  phase_q <= '0;
      else if (tick_en) phase_q <= phase_q + 1'b1;
      if (inc_ev) cnt <= cnt_next;
    end
  end
endmodule

// File: rtl/stt_alarm.sv
module stt_alarm #(
  parameter int CNT_W = 20
) (
  input  logic             inc_ev,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] alarm,
  output logic             alm_ev
);
  // fires only when the count steps into the alarm value
  assign alm_ev = inc_ev && (cnt_next == alarm);
endmodule

// File: rtl/stt_pit.sv
module stt_pit #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load,
  input  logic [PER_W-1:0] load_val,
  input  logic [PER_W-1:0] period,
  output logic             pit_ev
);
  function automatic logic [PER_W-1:0] period_len(input logic [PER_W-1:0] p);
    return (p == '0) ? {{(PER_W-1){1'b0}}, 1'b1} : p;
  endfunction

  logic [PER_W-1:0] left_q;

  assign pit_ev = tick_en && !load && (left_q <= {{(PER_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '1;
    else if (load)    left_q <= period_len(load_val);
    else if (pit_ev)  left_q <= period_len(period);
    else if (tick_en) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/stt_irq.sv
module stt_irq #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         rd_clr,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= (rd_clr ? '0 : status) | ev;
      mask   <= (mask | set_bits) & ~clr_bits;
    end
  end

  assign irq = |(status & mask);
endmodule

// File: rtl/slowtick_timer.sv
module slowtick_timer
  import stt_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int PRE_W    = 16,
  parameter int PER_W    = 16,
  parameter int DATA_W   = 32,
  parameter int PRE_RST  = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wd_ovf_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [PRE_W-1:0] presc_q;
  logic [CNT_W-1:0] alarm_q;
  logic [PER_W-1:0] period_q;
  logic [CNT_W-1:0] cnt, cnt_next;
  logic             inc_ev, alm_ev, pit_ev;
  logic [ST_W-1:0]  ev, status, mask, set_bits, clr_bits;
  logic             wr_presc, wr_alarm, wr_period, rd_stat;

  assign wr_presc  = wr_en && (addr == A_PRESC);
  assign wr_alarm  = wr_en && (addr == A_ALARM);
  assign wr_period = wr_en && (addr == A_PERIOD);
  assign rd_stat   = rd_en && (addr == A_STATUS);
  assign set_bits  = (wr_en && (addr == A_MSET)) ? wdata[ST_W-1:0] : '0;
  assign clr_bits  = (wr_en && (addr == A_MCLR)) ? wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q  <= PRE_W'(PRE_RST);
      alarm_q  <= '0;
      period_q <= '1;
    end else begin
      if (wr_presc)  presc_q  <= wdata[PRE_W-1:0];
      if (wr_alarm)  alarm_q  <= wdata[CNT_W-1:0];
      if (wr_period) period_q <= wdata[PER_W-1:0];
    end
  end

  stt_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .presc_load(wr_presc),
    .presc(presc_q), .cnt(cnt), .cnt_next(cnt_next), .inc_ev(inc_ev)
  );

  stt_alarm #(.CNT_W(CNT_W)) u_alarm (
    .inc_ev(inc_ev), .cnt_next(cnt_next), .alarm(alarm_q), .alm_ev(alm_ev)
  );

  stt_pit #(.PER_W(PER_W)) u_pit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(wr_period),
    .load_val(wdata[PER_W-1:0]), .period(period_q), .pit_ev(pit_ev)
  );

  always_comb begin
    ev         = '0;
    ev[ST_PIT] = pit_ev;
    ev[ST_WDG] = wd_ovf_in;
    ev[ST_INC] = inc_ev;
    ev[ST_ALM] = alm_ev;
  end

  stt_irq #(.W(ST_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .rd_clr(rd_stat),
    .set_bits(set_bits), .clr_bits(clr_bits),
    .status(status), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        A_CNT:    rdata <= DATA_W'(cnt);
        A_PRESC:  rdata <= DATA_W'(presc_q);
        A_ALARM:  rdata <= DATA_W'(alarm_q);
        A_PERIOD: rdata <= DATA_W'(period_q);
        A_STATUS: rdata <= DATA_W'(status);
        A_MASK:   rdata <= DATA_W'(mask);
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32,
  parameter int ST_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              wd_ovf_in,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              inc_ev,
  input logic              alm_ev,
  input logic              pit_ev,
  input logic [ST_W-1:0]   status,
  input logic [ST_W-1:0]   mask,
  input logic              irq
);
  a_r2_inc_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |-> tick_en);

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ev && (cnt == '1)) |=> (cnt == '0));

  a_r4_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alm_ev |=> status[3]);

  a_r12_inc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ev |=> status[2]);

  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 3'd4) && pit_ev) |=> status[0]);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 3'd4) && !inc_ev && !alm_ev && !pit_ev && !wd_ovf_in)
      |=> (status == '0));

  a_r10_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 3'd5)) |=>
      ((mask & $past(wdata[ST_W-1:0])) == $past(wdata[ST_W-1:0])));

  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind slowtick_timer stt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ST_W(stt_pkg::ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wd_ovf_in(wd_ovf_in),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .cnt(cnt),
  .inc_ev(inc_ev), .alm_ev(alm_ev), .pit_ev(pit_ev), .status(status),
  .mask(mask), .irq(irq)
);

// File: tb/slowtick_timer_tb.sv
`timescale 1ns/1ps
module slowtick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wd_ovf_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  // bench model of the time base
  int unsigned m_cnt = 0, m_pre = 0, m_presc = 32768;

  always #2.5 clk = ~clk;

  slowtick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wd_ovf_in(wd_ovf_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  function automatic void model_tick();
    int unsigned n = (m_presc == 0) ? 1 : m_presc;
    m_pre = m_pre + 1;
    if (m_pre >= n) begin
      m_pre = 0;
      m_cnt = (m_cnt + 1) % (1 << 20);
    end
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata, e, t);
    end
  end

  // all driver tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 3'd1) begin m_presc = d[15:0]; m_pre = 0; end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag,
                    input bit with_tick = 0);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a; tick_en = with_tick;
    @(negedge clk);
    rd_en = 1'b0; tick_en = 1'b0;
    if (with_tick) model_tick();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      model_tick();
    end
    tick_en = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq after reset");
    rd(3'd0, 32'd0, "R1 count");
    rd(3'd1, 32'd32768, "R1 prescale");
    rd(3'd2, 32'd0, "R1 alarm");
    rd(3'd3, 32'd65535, "R1 period");
    rd(3'd4, 32'd0, "R1 status");
    rd(3'd7, 32'd0, "R1 mask");

    // R2 default prescale: one increment per 32768 ticks
    ticks(32767);
    rd(3'd0, 32'd0, "R2 count before 32768th tick");
    ticks(1);
    rd(3'd0, m_cnt, "R2 count after 32768 ticks");
    rd(3'd4, 32'h4, "R12 increment bit");
    rd(3'd4, 32'h0, "R7 status cleared by read");

    // R2 prescale 1 and 0
    wr(3'd1, 32'd1);
    ticks(5);
    rd(3'd0, m_cnt, "R2 prescale 1 count");
    rd(3'd4, 32'h4, "R12 increment bit at prescale 1");
    rd(3'd4, 32'h0, "R7 second read empty");
    wr(3'd1, 32'd0);
    ticks(3);
    rd(3'd0, m_cnt, "R2 prescale 0 acts as 1");
    rd(3'd1, 32'd0, "R2 prescale readback");
    wr(3'd1, 32'd1);

    // R6 periodic timer, no drift
    wr(3'd5, 32'h1);
    wr(3'd3, 32'd4);
    rd(3'd4, 32'h4, "R7 status before period test");
    for (int i = 1; i <= 12; i++) begin
      ticks(1);
      chk({31'd0, irq}, {31'd0, (i % 4 == 0)}, $sformatf("R6 R11 irq at tick %0d", i));
      if (i % 4 == 0) rd(3'd4, 32'h5, "R6 periodic and increment bits");
    end
    rd(3'd4, 32'h0, "R7 status empty after period test");
    wr(3'd6, 32'h1);
    wr(3'd3, 32'd65535);

    // R4 alarm on stepping into the value
    wr(3'd5, 32'h8);
    wr(3'd2, m_cnt + 3);
    ticks(2);
    chk({31'd0, irq}, 32'd0, "R4 no alarm two ticks early");
    ticks(1);
    chk({31'd0, irq}, 32'd1, "R4 alarm irq");
    rd(3'd4, 32'hC, "R4 alarm bit");
    chk({31'd0, irq}, 32'd0, "R7 irq gone after status read");

    // R5 writing the current count cancels
    wr(3'd2, m_cnt);
    rd(3'd2, m_cnt, "R5 alarm readback");
    ticks(50);
    chk({31'd0, irq}, 32'd0, "R5 no alarm after current-count write");
    rd(3'd4, 32'h4, "R5 alarm bit stays clear");

    // R8 event during status read
    rd(3'd4, 32'h0, "R8 read with tick returns old status", 1);
    rd(3'd4, 32'h4, "R8 increment bit survived the read");

    // R9 watchdog input
    wd_ovf_in = 1'b1;
    @(negedge clk);
    wd_ovf_in = 1'b0;
    rd(3'd4, 32'h2, "R9 watchdog bit");
    wr(3'd5, 32'h2);
    wd_ovf_in = 1'b1;
    @(negedge clk);
    wd_ovf_in = 1'b0;
    chk({31'd0, irq}, 32'd1, "R11 watchdog irq");
    rd(3'd4, 32'h2, "R9 watchdog bit again");

    // R10 mask set/clear
    wr(3'd5, 32'hF);
    rd(3'd7, 32'hF, "R10 set all");
    wr(3'd6, 32'h5);
    rd(3'd7, 32'hA, "R10 clear bits 0 and 2");
    wr(3'd5, 32'h0);
    rd(3'd7, 32'hA, "R10 zero set has no effect");
    wr(3'd6, 32'h0);
    rd(3'd7, 32'hA, "R10 zero clear has no effect");
    chk({31'd0, irq}, 32'd0, "R11 irq low with empty status");

    // R3 count read timing and write ignore
    rd(3'd0, m_cnt, "R3 read with increment same edge", 1);
    rd(3'd0, m_cnt, "R3 read after increment");
    wr(3'd0, 32'd123);
    rd(3'd0, m_cnt, "R3 count write ignored");

    drain();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule